// File: doc/BRIEF.md
# Processor Sleep Controller

This block decides when a small processor core enters sleep and when it leaves it. The core signals a wait-for-interrupt or wait-for-event instruction with a one-cycle strobe. It also reports each exception return, together with whether the return goes back to thread mode. The controller then holds the core asleep until one of the wake rules is met. Those rules depend on the instruction that started the sleep, the interrupt priority mask, and a software-programmable send-event-on-pend option. On wake it gives a one-cycle wake pulse and a flag that says whether the pending handler should run or execution should simply resume.

A single memory-mapped control word at address `0xE000ED10` holds three option bits: sleep-on-exit, deep sleep and send-event-on-pend. Sleep-on-exit puts the core straight back to sleep when the last handler returns to thread mode, and tells the core to skip unstacking. An internal event latch records send-event inputs and, when enabled, new interrupt pends. Choosing which interrupt wins is done outside this block. It only receives a flag saying that a pending interrupt beats the current level, plus a separate non-maskable / hard-fault request.

Top module: `core_sleep_ctrl`

## Requirements
- R1: The control word is accessed at address 0xE000ED10. Bit 1 is sleep-on-exit, bit 2 is deep-sleep select and bit 4 is send-event-on-pend. It resets to 0. All other bits read 0 and ignore writes, and a write to any other address leaves the word unchanged.
- R2: A wait-for-interrupt strobe puts the core to sleep. That sleep ends only on an above-level interrupt (`irq_above`) or a non-maskable request (`nmi_req`). Pend edges and send-event do not end it.
- R3: On every wake, `run_handler` is 1 exactly when `nmi_req` was present or `irq_above` was present with `pmask` = 0. The priority mask never blocks `nmi_req`.
- R4: A wait-for-event sleep ends on `nmi_req`, on `irq_above` with `pmask` = 0, or on a send-event input. An above-level interrupt with `pmask` = 1 alone does not end it.
- R5: With send-event-on-pend set, any bit of `irq_pend_edge` ends a wait-for-event sleep without running a handler. With the option clear, pend edges have no effect.
- R6: If the event latch is already set when a wait-for-event strobe arrives, the core does not sleep and the latch is cleared, so a second strobe does sleep. Every wake from wait-for-event clears the latch.
- R7: With sleep-on-exit set, an exception return to thread mode puts the core to sleep with wait-for-interrupt wake rules, and pulses `skip_unstack` for one cycle.
- R8: An exception return to another handler, or any return while sleep-on-exit is clear, does not sleep and does not pulse `skip_unstack`.
- R9: `deep_sleep` is 1 only while `sleeping` is 1 and control bit 2 is 1.
- R10: All outputs except `bus_rdata` change one clock edge after the input that causes them. `wake` lasts one cycle and coincides with `sleeping` falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| wfi_req | input | 1 | Wait-for-interrupt executed |
| wfe_req | input | 1 | Wait-for-event executed |
| evt_in | input | 1 | Send-event input |
| exc_ret | input | 1 | Exception return strobe |
| ret_to_thread | input | 1 | Return target is thread mode |
| pmask | input | 1 | Priority mask bit |
| irq_above | input | 1 | A pending interrupt is above the current level |
| nmi_req | input | 1 | Non-maskable / hard-fault request |
| irq_pend_edge | input | NIRQ | Per-interrupt inactive-to-pending pulses |
| sleeping | output | 1 | Core is asleep |
| deep_sleep | output | 1 | Sleep is the deep kind |
| wake | output | 1 | One-cycle wake pulse |
| run_handler | output | 1 | Handler runs on this wake |
| skip_unstack | output | 1 | Sleep-on-exit taken; skip unstacking |

## Verification
Each strobe (wait-for-interrupt, wait-for-event, exception return) changes `sleeping`, `deep_sleep` and `skip_unstack` at the next rising edge. A wake stimulus likewise shows up on `wake`, `run_handler` and a falling `sleeping` one edge later. Register reads are combinational within the access cycle. The bench drives every stimulus on a falling edge and samples on the following falling edge, so each sample falls exactly one register stage after its cause. A sweep covers both sleep kinds, both mask values, both pend-option values and five wake stimuli, predicting wake and handler from the rule table.

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl #(
  parameter int          NIRQ      = 8,
  parameter logic [31:0] CTRL_ADDR = 32'hE000ED10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [31:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            wfi_req,
  input  logic            wfe_req,
  input  logic            evt_in,
  input  logic            exc_ret,
  input  logic            ret_to_thread,
  input  logic            pmask,
  input  logic            irq_above,
  input  logic            nmi_req,
  input  logic [NIRQ-1:0] irq_pend_edge,
  output logic            sleeping,
  output logic            deep_sleep,
  output logic            wake,
  output logic            run_handler,
  output logic            skip_unstack
);
  logic soe_q, deep_q, sevp_q;
  logic asleep_q, by_wfe_q, evt_q;

  wire hit     = bus_sel && (bus_addr == CTRL_ADDR);
  wire ctl_wr  = hit && bus_we;
  assign bus_rdata = (hit && !bus_we) ? {27'd0, sevp_q, 1'b0, deep_q, soe_q, 1'b0} : 32'd0;

  wire ev_set   = evt_in || (sevp_q && |irq_pend_edge);
  wire hnd      = nmi_req || (irq_above && !pmask);
  wire wake_c   = asleep_q && (by_wfe_q ? (hnd || evt_q || ev_set) : (nmi_req || irq_above));
  wire go_wfi   = !asleep_q && wfi_req;
  wire go_wfe   = !asleep_q && !wfi_req && wfe_req && !evt_q;
  wire wfe_skip = !asleep_q && !wfi_req && wfe_req && evt_q;
  wire go_exit  = !asleep_q && !wfi_req && !wfe_req && exc_ret && ret_to_thread && soe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soe_q  <= 1'b0;
      deep_q <= 1'b0;
      sevp_q <= 1'b0;
    end else if (ctl_wr) begin
      soe_q  <= bus_wdata[1];
      deep_q <= bus_wdata[2];
      sevp_q <= bus_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q     <= 1'b0;
      by_wfe_q     <= 1'b0;
      evt_q        <= 1'b0;
      wake         <= 1'b0;
      run_handler  <= 1'b0;
      skip_unstack <= 1'b0;
    end else begin
      wake         <= wake_c;
      run_handler  <= wake_c && hnd;
      skip_unstack <= go_exit;
      if (wake_c)
        asleep_q <= 1'b0;
      else if (go_wfi || go_wfe || go_exit) begin
        asleep_q <= 1'b1;
        by_wfe_q <= go_wfe;
      end
      if (wfe_skip || (wake_c && by_wfe_q))
        evt_q <= 1'b0;
      else if (ev_set)
        evt_q <= 1'b1;
    end
  end

  assign sleeping   = asleep_q;
  assign deep_sleep = asleep_q && deep_q;

  a_r2_wfi_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && wfi_req) |=> sleeping);
  a_r2_wfi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !by_wfe_q && !irq_above && !nmi_req) |=> sleeping);
  a_r3_handler_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    run_handler |-> wake);
  a_r6_preset_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && wfe_req && !wfi_req && evt_q) |=> (!sleeping && !evt_q));
  a_r7_exit_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && !wfi_req && !wfe_req && exc_ret && ret_to_thread && soe_q) |=> (sleeping && skip_unstack));
  a_r8_h2h_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && !wfi_req && !wfe_req && exc_ret && !ret_to_thread) |=> (!sleeping && !skip_unstack));
  a_r10_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  a_r10_wake_falls: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($fell(sleeping)));
endmodule

// File: tb/core_sleep_ctrl_bench.sv
module core_sleep_ctrl_bench;
  localparam int NIRQ = 8;
  localparam logic [31:0] CA = 32'hE000ED10;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic wfi_req = 0, wfe_req = 0, evt_in = 0, exc_ret = 0, ret_to_thread = 0;
  logic pmask = 0, irq_above = 0, nmi_req = 0;
  logic [NIRQ-1:0] irq_pend_edge = 0;
  logic sleeping, deep_sleep, wake, run_handler, skip_unstack;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  core_sleep_ctrl #(.NIRQ(NIRQ)) u_core_sleep_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    {wfi_req, wfe_req, evt_in, exc_ret, ret_to_thread, pmask, irq_above, nmi_req} = '0;
    irq_pend_edge = 0; bus_sel = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = CA;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  initial begin
    logic [31:0] v;
    do_reset();
    chk("R1 reset sleeping", {31'd0, sleeping}, 0);
    rd(v); chk("R1 reset value", v, 0);
    wr(CA, 32'hFFFF_FFFF); rd(v); chk("R1 reserved read zero", v, 32'h16);
    wr(CA + 4, 32'h0); rd(v); chk("R1 other address ignored", v, 32'h16);
    wr(CA, 32'h0); rd(v); chk("R1 cleared", v, 0);

    // sweep: kind x pmask x sevonpend x stimulus
    for (int k = 0; k < 2; k++)
      for (int pm = 0; pm < 2; pm++)
        for (int sv = 0; sv < 2; sv++)
          for (int st = 0; st < 5; st++) begin
            bit dp, ew, eh;
            dp = pm[0] ^ sv[0];
            do_reset();
            wr(CA, {27'd0, sv[0], 1'b0, dp, 2'b00});
            @(negedge clk); pmask = pm[0];
            if (k == 0) wfi_req = 1; else wfe_req = 1;
            @(negedge clk); wfi_req = 0; wfe_req = 0;
            chk(k == 0 ? "R2 wfi sleeps" : "R4 wfe sleeps", {31'd0, sleeping}, 1);
            chk("R9 deep while asleep", {31'd0, deep_sleep}, {31'd0, dp});
            case (st)
              1: irq_above = 1;
              2: irq_pend_edge = 8'h10;
              3: nmi_req = 1;
              4: evt_in = 1;
              default: ;
            endcase
            eh = (st == 3) || (st == 1 && pm == 0);
            if (k == 0) ew = (st == 1) || (st == 3);
            else ew = eh || (st == 4) || (st == 2 && sv == 1);
            @(negedge clk);
            irq_above = 0; irq_pend_edge = 0; nmi_req = 0; evt_in = 0;
            chk(k == 0 ? "R2 wfi wake rule" : (st == 2 ? "R5 pend edge wake" : "R4 wfe wake rule"),
                {31'd0, wake}, {31'd0, ew});
            chk("R3 handler flag", {31'd0, run_handler}, {31'd0, ew && eh});
            chk("R10 sleeping falls with wake", {31'd0, sleeping}, {31'd0, !ew});
            chk("R9 deep follows sleeping", {31'd0, deep_sleep}, {31'd0, !ew && dp});
            @(negedge clk);
            chk("R10 wake one cycle", {31'd0, wake}, 0);
          end

    // R6 pre-set latch
    do_reset();
    @(negedge clk); evt_in = 1;
    @(negedge clk); evt_in = 0; wfe_req = 1;
    @(negedge clk); wfe_req = 0;
    chk("R6 preset latch no sleep", {31'd0, sleeping}, 0);
    @(negedge clk); wfe_req = 1;
    @(negedge clk); wfe_req = 0;
    chk("R6 latch cleared then sleeps", {31'd0, sleeping}, 1);
    @(negedge clk); evt_in = 1;
    @(negedge clk); evt_in = 0;
    chk("R4 send-event wakes", {31'd0, wake}, 1);
    @(negedge clk); wfe_req = 1;
    @(negedge clk); wfe_req = 0;
    chk("R6 wake cleared latch", {31'd0, sleeping}, 1);

    // R7 / R8 sleep-on-exit
    do_reset();
    wr(CA, 32'h6);
    @(negedge clk); exc_ret = 1; ret_to_thread = 0;
    @(negedge clk); exc_ret = 0;
    chk("R8 handler to handler awake", {31'd0, sleeping}, 0);
    chk("R8 no skip on nested", {31'd0, skip_unstack}, 0);
    @(negedge clk); exc_ret = 1; ret_to_thread = 1;
    @(negedge clk); exc_ret = 0; ret_to_thread = 0;
    chk("R7 exit sleeps", {31'd0, sleeping}, 1);
    chk("R7 skip unstack", {31'd0, skip_unstack}, 1);
    chk("R9 deep on exit", {31'd0, deep_sleep}, 1);
    @(negedge clk); evt_in = 1;
    @(negedge clk); evt_in = 0;
    chk("R7 wfi rules ignore event", {31'd0, sleeping}, 1);
    chk("R7 skip is a pulse", {31'd0, skip_unstack}, 0);
    @(negedge clk); irq_above = 1; pmask = 1;
    @(negedge clk); irq_above = 0; pmask = 0;
    chk("R3 masked wake no handler", {31'd0, run_handler}, 0);
    chk("R2 above wakes", {31'd0, wake}, 1);
    wr(CA, 32'h0);
    @(negedge clk); exc_ret = 1; ret_to_thread = 1;
    @(negedge clk); exc_ret = 0; ret_to_thread = 0;
    chk("R8 option clear no sleep", {31'd0, sleeping}, 0);
    chk("R8 option clear no skip", {31'd0, skip_unstack}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule